// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and passes data between them in either direction. Each direction owns a storage register with its own capture strobe, a select that chooses live or stored data, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. Both may be on at the same time.

The buses are modelled without tri-state nets. Each side has an input vector, a flag that says an outside agent is driving it, a data output and an output-enable vector. A bus with no active driver reads as the value it last carried, which is kept in a small per-bus state register clocked by the system clock. The capture strobes are sampled on the system clock, and a register loads on each low-to-high change of its strobe, whatever the selects and enables are doing.

When both directions are enabled with live data and nothing outside drives either bus, each port re-drives its own bus's last value, so both buses hold still. A build-time parameter picks a true or an inverting path between the buses.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On a cycle in which `capAtoB` is high and was low in the previous cycle, the A-to-B register loads the current A-bus value. The A-bus value is `aIn` when `aExtDrive` is 1 and otherwise the A bus's held last value. The loaded value appears on `bOut` from the next cycle when `selAtoB` is 1. The B-to-A register loads from the B bus on rising edges of `capBtoA` in the same way.
- R2: Register loads happen whatever the values of the selects and the enables, including while both output enables are inactive.
- R3: With `selAtoB` at 0, `bOut` carries the A-bus value of the same cycle through the data path. With `selBtoA` at 0, `aOut` carries the B-bus value in the same way. This does not apply to the R6 case.
- R4: With `selAtoB` at 1, `bOut` carries the A-to-B register. With `selBtoA` at 1, `aOut` carries the B-to-A register.
- R5: `bOe` is all ones when `enAtoB` is 1 and all zeros when it is 0. `aOe` is all ones when `enBtoAN` is 0 and all zeros when it is 1.
- R6: Both enables active, both selects at 0, and neither external-drive flag set: `aOut` equals the A bus's held value and `bOut` equals the B bus's held value. Both stay unchanged for as long as the condition lasts.
- R7: When `INVERT` is 1, every live and stored transfer is bitwise inverted relative to the `INVERT` = 0 case. The held-value re-drive of R6 is not inverted.
- R8: A synchronous `rst` clears both storage registers, both held bus values and the strobe edge history to zero.
- R9: A bus held value updates to `aIn` (`bIn`) when its external-drive flag is 1. Otherwise it updates to the block's own output when that output is enabled. Otherwise it keeps its value.
- R10: A capture strobe held high for several cycles loads only once. A register keeps its value on every cycle without a rising strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | DATA_W | Value an outside agent places on the A bus |
| aExtDrive | input | 1 | An outside agent drives the A bus |
| bIn | input | DATA_W | Value an outside agent places on the B bus |
| bExtDrive | input | 1 | An outside agent drives the B bus |
| capAtoB | input | 1 | Capture strobe of the A-to-B register; loads on a rising edge |
| capBtoA | input | 1 | Capture strobe of the B-to-A register; loads on a rising edge |
| selAtoB | input | 1 | 0 = live A data to B, 1 = stored A-to-B register |
| selBtoA | input | 1 | 0 = live B data to A, 1 = stored B-to-A register |
| enAtoB | input | 1 | B-side output enable, active high |
| enBtoAN | input | 1 | A-side output enable, active low |
| aOut | output | DATA_W | Data driven toward the A bus |
| aOe | output | DATA_W | Per-bit output enable toward the A bus |
| bOut | output | DATA_W | Data driven toward the B bus |
| bOe | output | DATA_W | Per-bit output enable toward the B bus |

## Verification
A register load and a read of that same register can fall in the same cycle. The bench raises a capture strobe while the select already shows stored data. It expects the old contents on the output in that cycle and the new contents from the next cycle. A load can also coincide with the bus-hold loop. The bench toggles the strobes while both ports are enabled in live mode with no outside driver. It checks that the buses stay frozen while the registers still pick up the held values, and that the loads later show through the stored-data path. A cycle-level model in the bench computes every output, and both a true and an inverting instance are compared against it on every clock.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  typedef struct packed {
    logic capAB;
    logic capBA;
    logic driveB;
    logic driveA;
    logic useRegB;
    logic useRegA;
    logic loop;
  } xcvrStrobe_t;

endpackage

// File: rtl/bxr_ctrl.sv
module bxr_ctrl
  import bxr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        capAtoB,
  input  logic        capBtoA,
  input  logic        selAtoB,
  input  logic        selBtoA,
  input  logic        enAtoB,
  input  logic        enBtoAN,
  input  logic        aExtDrive,
  input  logic        bExtDrive,
  output xcvrStrobe_t strb
);

  logic prevCapAB;
  logic prevCapBA;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCapAB <= 1'b0;
      prevCapBA <= 1'b0;
    end else begin
      prevCapAB <= capAtoB;
      prevCapBA <= capBtoA;
    end
  end

  always_comb begin
    strb.capAB   = capAtoB & ~prevCapAB;
    strb.capBA   = capBtoA & ~prevCapBA;
    strb.driveB  = enAtoB;
    strb.driveA  = ~enBtoAN;
    strb.useRegB = selAtoB;
    strb.useRegA = selBtoA;
    strb.loop    = enAtoB & ~enBtoAN & ~selAtoB & ~selBtoA
                   & ~aExtDrive & ~bExtDrive;
  end

  // R10: a rising edge yields a single-cycle load pulse
  p_cap_pulse_ab_r10: assert property (@(posedge clk) disable iff (rst)
    strb.capAB |=> !strb.capAB);
  p_cap_pulse_ba_r10: assert property (@(posedge clk) disable iff (rst)
    strb.capBA |=> !strb.capBA);

endmodule

// File: rtl/bxr_datapath.sv
module bxr_datapath
  import bxr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  xcvrStrobe_t       strb,
  input  logic [DATA_W-1:0] aIn,
  input  logic              aExtDrive,
  input  logic [DATA_W-1:0] bIn,
  input  logic              bExtDrive,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aOe,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bOe
);

  logic [DATA_W-1:0] regAB;
  logic [DATA_W-1:0] regBA;
  logic [DATA_W-1:0] lastA;
  logic [DATA_W-1:0] lastB;
  logic [DATA_W-1:0] aSeen;
  logic [DATA_W-1:0] bSeen;
  logic [DATA_W-1:0] aSeenXf;
  logic [DATA_W-1:0] bSeenXf;
  logic [DATA_W-1:0] regABXf;
  logic [DATA_W-1:0] regBAXf;

  assign aSeen = aExtDrive ? aIn : lastA;
  assign bSeen = bExtDrive ? bIn : lastB;

  generate
    if (INVERT) begin : g_inv
      assign aSeenXf = ~aSeen;
      assign bSeenXf = ~bSeen;
      assign regABXf = ~regAB;
      assign regBAXf = ~regBA;
    end else begin : g_true
      assign aSeenXf = aSeen;
      assign bSeenXf = bSeen;
      assign regABXf = regAB;
      assign regBAXf = regBA;
    end
  endgenerate

  always_comb begin
    if (strb.loop)         bOut = lastB;
    else if (strb.useRegB) bOut = regABXf;
    else                   bOut = aSeenXf;
    if (strb.loop)         aOut = lastA;
    else if (strb.useRegA) aOut = regBAXf;
    else                   aOut = bSeenXf;
  end

  assign bOe = {DATA_W{strb.driveB}};
  assign aOe = {DATA_W{strb.driveA}};

  always_ff @(posedge clk) begin
    if (rst) begin
      regAB <= '0;
      regBA <= '0;
      lastA <= '0;
      lastB <= '0;
    end else begin
      if (strb.capAB) regAB <= aSeen;
      if (strb.capBA) regBA <= bSeen;
      if (aExtDrive)        lastA <= aIn;
      else if (strb.driveA) lastA <= aOut;
      if (bExtDrive)        lastB <= bIn;
      else if (strb.driveB) lastB <= bOut;
    end
  end

  // R1: a load pulse stores the bus value seen in that cycle
  p_cap_load_r1: assert property (@(posedge clk) disable iff (rst)
    strb.capAB |=> regAB == $past(aSeen));
  // R10: no pulse, no change
  p_reg_keep_r10: assert property (@(posedge clk) disable iff (rst)
    !strb.capBA |=> $stable(regBA));
  // R6: the hold loop freezes both outputs
  p_loop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    strb.loop |=> (strb.loop -> ($stable(aOut) && $stable(bOut))));
  // R9: an undriven bus keeps its last value
  p_undriven_r9: assert property (@(posedge clk) disable iff (rst)
    (!aExtDrive && !strb.driveA) |=> lastA == $past(lastA));

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bxr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] aIn,
  input  logic              aExtDrive,
  input  logic [DATA_W-1:0] bIn,
  input  logic              bExtDrive,
  input  logic              capAtoB,
  input  logic              capBtoA,
  input  logic              selAtoB,
  input  logic              selBtoA,
  input  logic              enAtoB,
  input  logic              enBtoAN,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] aOe,
  output logic [DATA_W-1:0] bOut,
  output logic [DATA_W-1:0] bOe
);

  xcvrStrobe_t strb;

  bxr_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .capAtoB   (capAtoB),
    .capBtoA   (capBtoA),
    .selAtoB   (selAtoB),
    .selBtoA   (selBtoA),
    .enAtoB    (enAtoB),
    .enBtoAN   (enBtoAN),
    .aExtDrive (aExtDrive),
    .bExtDrive (bExtDrive),
    .strb      (strb)
  );

  bxr_datapath #(.DATA_W(DATA_W), .INVERT(INVERT)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .aIn       (aIn),
    .aExtDrive (aExtDrive),
    .bIn       (bIn),
    .bExtDrive (bExtDrive),
    .aOut      (aOut),
    .aOe       (aOe),
    .bOut      (bOut),
    .bOe       (bOe)
  );

  // R5: enable polarity at the ports
  p_oe_a_r5: assert property (@(posedge clk) disable iff (rst)
    (|aOe) |-> !enBtoAN);
  p_oe_b_r5: assert property (@(posedge clk) disable iff (rst)
    enAtoB |-> (&bOe));

endmodule

// File: tb/bus_xcvr_reg_test.sv
`timescale 1ns/1ps
module bus_xcvr_reg_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] aIn, bIn;
  logic aExt, bExt, cab, cba, sAB, sBA, enAB, enBAn;
  logic [W-1:0] aOut0, aOe0, bOut0, bOe0;
  logic [W-1:0] aOut1, aOe1, bOut1, bOe1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W-1:0] mRegAB[2], mRegBA[2], mLastA[2], mLastB[2];
  logic mPrevAB, mPrevBA;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.DATA_W(W), .INVERT(1'b0)) uut (
    .clk(clk), .rst(rst), .aIn(aIn), .aExtDrive(aExt), .bIn(bIn), .bExtDrive(bExt),
    .capAtoB(cab), .capBtoA(cba), .selAtoB(sAB), .selBtoA(sBA),
    .enAtoB(enAB), .enBtoAN(enBAn),
    .aOut(aOut0), .aOe(aOe0), .bOut(bOut0), .bOe(bOe0));

  bus_xcvr_reg #(.DATA_W(W), .INVERT(1'b1)) uutInv (
    .clk(clk), .rst(rst), .aIn(aIn), .aExtDrive(aExt), .bIn(bIn), .bExtDrive(bExt),
    .capAtoB(cab), .capBtoA(cba), .selAtoB(sAB), .selBtoA(sBA),
    .enAtoB(enAB), .enBtoAN(enBAn),
    .aOut(aOut1), .aOe(aOe1), .bOut(bOut1), .bOe(bOe1));

  function automatic logic [W-1:0] xf(input logic [W-1:0] v, input int inv);
    return (inv != 0) ? ~v : v;
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Wait for the falling edge, compare both instances, then advance the model.
  task automatic step(input string tag);
    logic loopOn, capAB, capBA;
    logic [W-1:0] aSeen, bSeen, eA, eB, actA, actB, actAOe, actBOe;
    @(negedge clk);
    loopOn = enAB & ~enBAn & ~sAB & ~sBA & ~aExt & ~bExt;
    capAB = cab & ~mPrevAB;
    capBA = cba & ~mPrevBA;
    for (int i = 0; i < 2; i++) begin
      aSeen = aExt ? aIn : mLastA[i];
      bSeen = bExt ? bIn : mLastB[i];
      eB = loopOn ? mLastB[i] : (sAB ? xf(mRegAB[i], i) : xf(aSeen, i));
      eA = loopOn ? mLastA[i] : (sBA ? xf(mRegBA[i], i) : xf(bSeen, i));
      actA   = (i == 0) ? aOut0 : aOut1;
      actB   = (i == 0) ? bOut0 : bOut1;
      actAOe = (i == 0) ? aOe0 : aOe1;
      actBOe = (i == 0) ? bOe0 : bOe1;
      cmp(tag, "bOe (R5)", actBOe, enAB ? '1 : '0);
      cmp(tag, "aOe (R5)", actAOe, enBAn ? '0 : '1);
      if (enAB)  cmp(tag, (i == 0) ? "bOut true" : "bOut inverting (R7)", actB, eB);
      if (!enBAn) cmp(tag, (i == 0) ? "aOut true" : "aOut inverting (R7)", actA, eA);
      if (rst) begin
        mRegAB[i] = '0; mRegBA[i] = '0; mLastA[i] = '0; mLastB[i] = '0;
      end else begin
        if (capAB) mRegAB[i] = aSeen;
        if (capBA) mRegBA[i] = bSeen;
        if (aExt) mLastA[i] = aIn; else if (!enBAn) mLastA[i] = eA;
        if (bExt) mLastB[i] = bIn; else if (enAB) mLastB[i] = eB;
      end
    end
    if (rst) begin mPrevAB = 1'b0; mPrevBA = 1'b0; end
    else begin mPrevAB = cab; mPrevBA = cba; end
    @(posedge clk);
    #1;
  endtask

  task automatic rndData();
    aIn = W'($urandom); bIn = W'($urandom);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; aIn = '0; bIn = '0; aExt = 1'b1; bExt = 1'b1;
    cab = 1'b0; cba = 1'b0; sAB = 1'b0; sBA = 1'b0; enAB = 1'b0; enBAn = 1'b1;
    mPrevAB = 1'b0; mPrevBA = 1'b0;
    for (int i = 0; i < 2; i++) begin
      mRegAB[i] = '0; mRegBA[i] = '0; mLastA[i] = '0; mLastB[i] = '0;
    end
    @(posedge clk); #1;
    // R8: reset clears registers even with strobes toggling
    for (int k = 0; k < 4; k++) begin
      rndData(); cab = k[0]; cba = ~k[0];
      step("R8 reset");
    end
    rst = 1'b0; cab = 1'b0; cba = 1'b0;
    sAB = 1'b1; sBA = 1'b1; enAB = 1'b1; enBAn = 1'b0;
    step("R8 cleared registers");
    step("R8 cleared registers");
    // R3 R5 R7: live transfer under varied enables
    sAB = 1'b0; sBA = 1'b0;
    for (int k = 0; k < 40; k++) begin
      rndData(); enAB = k[0]; enBAn = k[1];
      aExt = 1'b1; bExt = 1'b1;
      step("R3 live transfer");
    end
    // R1 R4: stored data, strobes toggling, load and read in the same cycle
    enAB = 1'b1; enBAn = 1'b0; sAB = 1'b1; sBA = 1'b1;
    for (int k = 0; k < 60; k++) begin
      rndData(); cab = 1'($urandom); cba = 1'($urandom);
      step("R1 R4 stored path");
    end
    // R2: loads while both ports disabled, then read back
    enAB = 1'b0; enBAn = 1'b1;
    for (int k = 0; k < 40; k++) begin
      rndData(); cab = k[0]; cba = k[1]; sAB = 1'($urandom); sBA = 1'($urandom);
      step("R2 load while disabled");
    end
    cab = 1'b0; cba = 1'b0; rndData();
    enAB = 1'b1; enBAn = 1'b0; sAB = 1'b1; sBA = 1'b1;
    for (int k = 0; k < 3; k++) step("R2 readback");
    // R10: strobe held high loads once
    cab = 1'b1; cba = 1'b1;
    for (int k = 0; k < 20; k++) begin
      rndData(); step("R10 strobe held");
    end
    cab = 1'b0; cba = 1'b0;
    // R9: undriven buses keep their last value
    sAB = 1'b0; sBA = 1'b0;
    for (int k = 0; k < 30; k++) begin
      rndData(); aExt = 1'($urandom); bExt = 1'($urandom);
      enAB = 1'($urandom); enBAn = 1'($urandom);
      step("R9 undriven bus");
    end
    // R6: settle buses, then close the hold loop with strobes toggling
    aExt = 1'b1; bExt = 1'b0; enAB = 1'b1; enBAn = 1'b1; rndData();
    step("R6 settle"); step("R6 settle");
    aExt = 1'b0; bExt = 1'b0; enBAn = 1'b0;
    for (int k = 0; k < 20; k++) begin
      rndData(); cab = k[0]; cba = k[1];
      step("R6 hold loop");
    end
    cab = 1'b0; cba = 1'b0; sAB = 1'b1; sBA = 1'b1;
    step("R6 R1 load during loop readback");
    // mixed: everything random
    for (int k = 0; k < 400; k++) begin
      rndData();
      aExt = 1'($urandom); bExt = 1'($urandom); cab = 1'($urandom); cba = 1'($urandom);
      sAB = 1'($urandom); sBA = 1'($urandom); enAB = 1'($urandom); enBAn = 1'($urandom);
      rst = (($urandom % 64) == 0);
      step("R3 R4 R8 mixed");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule